// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Corrector

This block repairs a page buffer after a Reed-Solomon decoder has located the errors. The codeword uses 12-bit symbols. Two symbols are packed into every three bytes, across a 2048-byte data area and the error-correction bytes that follow it. The spare bytes sit at buffer addresses 2048 and up, so one byte-wide RAM port reaches the whole page. A single start pulse hands over up to four (symbol position, 12-bit error pattern) pairs. The block turns each pair into one or two byte addresses, each with a nibble-aligned XOR mask.

Each masked byte is updated by read-modify-write on a synchronous RAM port: one read cycle, then one write cycle. Pairs are handled in index order. Symbol 0 carries only eight real data bits. A position past the last coded symbol cannot be corrected. Either case stops the run and flags the page as uncorrectable, and any writes already made stay in the buffer. A one-cycle done pulse closes every run and reports pass or fail and the number of symbols fixed.

Top module: `rs_symfix`

## Requirements
- R1: For an odd position p, byte 3p/2 (integer division) is XORed with pattern bits 11:4, then byte 3p/2+1 is XORed with pattern bits 3:0 placed in its high nibble.
- R2: For an even position p other than 0, byte 3p/2-1 is XORed with pattern bits 11:8 placed in its low nibble, then byte 3p/2 is XORed with pattern bits 7:0.
- R3: Position 0 makes a single access that XORs byte 0 with pattern bits 7:0 when pattern bits 11:8 are zero. If any of those bits is set, the pair fails.
- R4: Position 1365 updates data byte 2047 with pattern bits 11:4 and the high nibble of address 2048 (first spare byte) with pattern bits 3:0.
- R5: Positions 1366 to 1374 follow R1/R2 and land on addresses 2048 to 2061 in the spare area.
- R6: A position above 1374 fails without any RAM access.
- R7: Each byte update is a read cycle followed directly by a write cycle to the same address. The write data is the read data XOR the mask. A two-byte pair therefore takes four cycles, in rising address order. Pair k is taken from pos_i[11k+10:11k] and pat_i[12k+11:12k], with k=0 first. done_o is high for exactly one cycle, the cycle after the last write.
- R8: At the first failing pair the run stops. That pair and all later pairs make no access, and writes from earlier pairs are kept. At done, fail_o=1 and fixed_o=0.
- R9: On success, done_o comes with fail_o=0 and fixed_o equal to the pair count. With a count of zero, done_o rises in the cycle after start and no access is made.
- R10: A start pulse while a run is in progress is ignored, and so are changes to cnt_i, pos_i and pat_i after the start cycle.
- R11: A cnt_i above four is treated as four.
- R12: After reset, no read, write or done is driven, and fail_o and fixed_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| cnt_i | input | 3 | Number of valid pairs |
| pos_i | input | 44 | Four packed 11-bit symbol positions |
| pat_i | input | 48 | Four packed 12-bit error patterns |
| mem_addr_o | output | 12 | Buffer byte address |
| mem_rd_o | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Corrected byte |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Page uncorrectable; valid at done and held |
| fixed_o | output | 3 | Symbols corrected; valid at done and held |

## Verification
The assertions assume that the RAM returns read data in the cycle after a read strobe, and that nothing else writes the buffer during a run. The bench RAM satisfies this: it is a plain synchronous array that only the block drives. The assertions also assume start_i is sampled only when idle. The bench deliberately pokes start_i mid-run with different pairs to show it is ignored. Stimulus covers odd, even, zero, boundary, spare-area and out-of-range positions, overlapping pairs that share a byte, and mid-run failure.

// File: rtl/rs_symfix_pkg.sv
package rs_symfix_pkg;
  localparam int unsigned SYM_W  = 12;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } st_e;
endpackage

// File: rtl/rs_symfix_pairs.sv
module rs_symfix_pairs
  import rs_symfix_pkg::*;
#(
  parameter int unsigned MAX_ERR = 4,
  parameter int unsigned POS_W   = 11,
  parameter int unsigned CNT_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       bypass_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [MAX_ERR*POS_W-1:0]   pos_i,
  input  logic [MAX_ERR*SYM_W-1:0]   pat_i,
  input  logic [CNT_W-1:0]           sel_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [POS_W-1:0]           pos_o,
  output logic [SYM_W-1:0]           pat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ERR);

  logic [MAX_ERR*POS_W-1:0] pos_q, pos_src;
  logic [MAX_ERR*SYM_W-1:0] pat_q, pat_src;
  logic [CNT_W-1:0]         cnt_q, cnt_clamp;
  logic [POS_W-1:0]         pos_arr [MAX_ERR];
  logic [SYM_W-1:0]         pat_arr [MAX_ERR];

  // R11 clamp
  assign cnt_clamp = (cnt_i > CNT_MAX) ? CNT_MAX : cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      pat_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pos_q <= pos_i;
      pat_q <= pat_i;
      cnt_q <= cnt_clamp;
    end
  end

  // idle: steer live inputs so the first pair dispatches in the start cycle
  assign pos_src = bypass_i ? pos_i : pos_q;
  assign pat_src = bypass_i ? pat_i : pat_q;
  assign cnt_o   = bypass_i ? cnt_clamp : cnt_q;

  for (genvar k = 0; k < MAX_ERR; k++) begin : g_unpack
    assign pos_arr[k] = pos_src[k*POS_W +: POS_W];
    assign pat_arr[k] = pat_src[k*SYM_W +: SYM_W];
  end

  always_comb begin
    pos_o = '0;
    pat_o = '0;
    for (int k = 0; k < MAX_ERR; k++) begin
      if (sel_i == CNT_W'(k)) begin
        pos_o = pos_arr[k];
        pat_o = pat_arr[k];
      end
    end
  end
endmodule

// File: rtl/rs_symfix_map.sv
module rs_symfix_map
  import rs_symfix_pkg::*;
#(
  parameter int unsigned POS_W    = 11,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LAST_POS = 1374
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SYM_W-1:0]  pat_i,
  output logic              ok_o,
  output logic              two_o,
  output logic [ADDR_W-1:0] a0_o,
  output logic [ADDR_W-1:0] a1_o,
  output logic [BYTE_W-1:0] m0_o,
  output logic [BYTE_W-1:0] m1_o
);
  localparam int unsigned W = POS_W + 2;
  localparam logic [POS_W-1:0] LAST_P = POS_W'(LAST_POS);

  logic [W-1:0] base;
  logic         is_zero, in_rng, hi_set;

  // 3p/2 as (p + 2p) >> 1
  assign base    = ({2'b00, pos_i} + {1'b0, pos_i, 1'b0}) >> 1;
  assign is_zero = (pos_i == '0);
  assign in_rng  = (pos_i <= LAST_P);
  assign hi_set  = |pat_i[SYM_W-1:BYTE_W];

  assign ok_o  = in_rng && !(is_zero && hi_set);
  assign two_o = !is_zero;

  always_comb begin
    if (is_zero) begin
      // only 8 real bits in symbol 0
      a0_o = '0;
      m0_o = pat_i[BYTE_W-1:0];
      a1_o = '0;
      m1_o = '0;
    end else if (pos_i[0]) begin
      a0_o = ADDR_W'(base);
      m0_o = pat_i[SYM_W-1:NIB_W];
      a1_o = ADDR_W'(base + 1'b1);
      m1_o = {pat_i[NIB_W-1:0], {NIB_W{1'b0}}};
    end else begin
      a0_o = ADDR_W'(base - 1'b1);
      m0_o = {{NIB_W{1'b0}}, pat_i[SYM_W-1:BYTE_W]};
      a1_o = ADDR_W'(base);
      m1_o = pat_i[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/rs_symfix_ctrl.sv
module rs_symfix_ctrl
  import rs_symfix_pkg::*;
#(
  parameter int unsigned MAX_ERR   = 4,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MEM_BYTES = 2112
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_eff_i,
  input  logic              ok_i,
  input  logic              two_i,
  input  logic [ADDR_W-1:0] a0_i,
  input  logic [ADDR_W-1:0] a1_i,
  input  logic [BYTE_W-1:0] m0_i,
  input  logic [BYTE_W-1:0] m1_i,
  output logic              load_o,
  output logic              bypass_o,
  output logic [CNT_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  fixed_o
);
  localparam logic [ADDR_W-1:0] ADDR_LIM = ADDR_W'(MEM_BYTES);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_ERR);

  st_e               state_q;
  logic [CNT_W-1:0]  idx_q, nxt_idx, cnt_q;
  logic              sel_b_q, two_q, fail_q;
  logic [ADDR_W-1:0] a0_q, a1_q;
  logic [BYTE_W-1:0] m0_q, m1_q;
  logic              idle, at_disp, disp_end;

  assign idle     = (state_q == ST_IDLE);
  assign at_disp  = (idle && start_i) || (state_q == ST_WR && (sel_b_q || !two_q));
  assign nxt_idx  = idle ? '0 : idx_q + 1'b1;
  assign disp_end = (nxt_idx >= cnt_eff_i);

  assign load_o   = idle && start_i;
  assign bypass_o = idle;
  assign sel_o    = nxt_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sel_b_q <= 1'b0;
      two_q   <= 1'b0;
      a0_q    <= '0;
      a1_q    <= '0;
      m0_q    <= '0;
      m1_q    <= '0;
      fail_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (idle && start_i) begin
        fail_q <= 1'b0;
        cnt_q  <= '0;
      end
      if (at_disp) begin
        if (disp_end) begin
          state_q <= ST_FIN;
          cnt_q   <= cnt_eff_i;
        end else if (!ok_i) begin
          state_q <= ST_FIN;
          fail_q  <= 1'b1;
          cnt_q   <= '0;
        end else begin
          state_q <= ST_RD;
          idx_q   <= nxt_idx;
          sel_b_q <= 1'b0;
          two_q   <= two_i;
          a0_q    <= a0_i;
          a1_q    <= a1_i;
          m0_q    <= m0_i;
          m1_q    <= m1_i;
        end
      end else begin
        unique case (state_q)
          ST_RD:   state_q <= ST_WR;
          ST_WR: begin
            sel_b_q <= 1'b1;
            state_q <= ST_RD;
          end
          ST_FIN:  state_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign mem_rd_o    = (state_q == ST_RD);
  assign mem_wr_o    = (state_q == ST_WR);
  assign mem_addr_o  = sel_b_q ? a1_q : a0_q;
  assign mem_wdata_o = mem_rdata_i ^ (sel_b_q ? m1_q : m0_q);
  assign done_o      = (state_q == ST_FIN);
  assign fail_o      = fail_q;
  assign fixed_o     = cnt_q;

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  // R7
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o) && mem_addr_o == $past(mem_addr_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  fail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (fixed_o == '0));

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fixed_o <= CNT_MAX));

  // R5
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (mem_addr_o < ADDR_LIM));

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && start_i) |=> mem_wr_o);
endmodule

// File: rtl/rs_symfix.sv
module rs_symfix
  import rs_symfix_pkg::*;
#(
  parameter int unsigned DATA_BYTES  = 2048,
  parameter int unsigned SPARE_BYTES = 64,
  parameter int unsigned ECC_BYTES   = 14,
  parameter int unsigned MAX_ERR     = 4,
  localparam int unsigned MEM_BYTES  = DATA_BYTES + SPARE_BYTES,
  localparam int unsigned ADDR_W     = $clog2(MEM_BYTES),
  localparam int unsigned LAST_POS   = ((DATA_BYTES + ECC_BYTES) * 8 + SYM_W - 8) / SYM_W - 1,
  localparam int unsigned POS_W      = $clog2(LAST_POS + 1),
  localparam int unsigned CNT_W      = $clog2(MAX_ERR + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [MAX_ERR*POS_W-1:0] pos_i,
  input  logic [MAX_ERR*SYM_W-1:0] pat_i,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic                     mem_rd_o,
  output logic                     mem_wr_o,
  output logic [BYTE_W-1:0]        mem_wdata_o,
  input  logic [BYTE_W-1:0]        mem_rdata_i,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [CNT_W-1:0]         fixed_o
);
  logic              load, bypass;
  logic [CNT_W-1:0]  sel, cnt_eff;
  logic [POS_W-1:0]  cur_pos;
  logic [SYM_W-1:0]  cur_pat;
  logic              ok, two;
  logic [ADDR_W-1:0] a0, a1;
  logic [BYTE_W-1:0] m0, m1;

  rs_symfix_pairs #(
    .MAX_ERR (MAX_ERR),
    .POS_W   (POS_W),
    .CNT_W   (CNT_W)
  ) u_pairs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .bypass_i (bypass),
    .cnt_i    (cnt_i),
    .pos_i    (pos_i),
    .pat_i    (pat_i),
    .sel_i    (sel),
    .cnt_o    (cnt_eff),
    .pos_o    (cur_pos),
    .pat_o    (cur_pat)
  );

  rs_symfix_map #(
    .POS_W    (POS_W),
    .ADDR_W   (ADDR_W),
    .LAST_POS (LAST_POS)
  ) u_map (
    .pos_i (cur_pos),
    .pat_i (cur_pat),
    .ok_o  (ok),
    .two_o (two),
    .a0_o  (a0),
    .a1_o  (a1),
    .m0_o  (m0),
    .m1_o  (m1)
  );

  rs_symfix_ctrl #(
    .MAX_ERR   (MAX_ERR),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .MEM_BYTES (MEM_BYTES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cnt_eff_i   (cnt_eff),
    .ok_i        (ok),
    .two_i       (two),
    .a0_i        (a0),
    .a1_i        (a1),
    .m0_i        (m0),
    .m1_i        (m1),
    .load_o      (load),
    .bypass_o    (bypass),
    .sel_o       (sel),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fixed_o     (fixed_o)
  );
endmodule

// File: tb/rs_symfix_tb.sv
`timescale 1ns/1ps
module rs_symfix_tb;
  localparam int MEMB = 2112;
  localparam int LASTP = 1374;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        done;
    logic        fail;
    logic [2:0]  cnt;
    logic [11:0] addr;
    logic [7:0]  wd;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cnt = '0;
  logic [43:0] pos_v = '0;
  logic [47:0] pat_v = '0;
  logic [11:0] addr;
  logic        rd, wr, done, fail;
  logic [7:0]  wdata, rdata;
  logic [2:0]  fixed;

  logic [7:0] ram    [MEMB];
  logic [7:0] shadow [MEMB];
  int tp_pos [4];
  int tp_pat [4];
  rec_t exp_q [$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rs_symfix u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .cnt_i       (cnt),
    .pos_i       (pos_v),
    .pat_i       (pat_v),
    .mem_addr_o  (addr),
    .mem_rd_o    (rd),
    .mem_wr_o    (wr),
    .mem_wdata_o (wdata),
    .mem_rdata_i (rdata),
    .done_o      (done),
    .fail_o      (fail),
    .fixed_o     (fixed)
  );

  always @(posedge clk) begin
    if (wr) ram[addr] <= wdata;
    if (rd) rdata <= ram[addr];
  end

  function automatic rec_t mk(bit r, bit w, bit d, bit f, int c, int a, int v);
    rec_t x;
    x.rd = r; x.wr = w; x.done = d; x.fail = f;
    x.cnt = 3'(c); x.addr = 12'(a); x.wd = 8'(v);
    return x;
  endfunction

  task automatic set_pair(int k, int p, int t);
    tp_pos[k] = p;
    tp_pat[k] = t;
  endtask

  // behavioural model: symbol p occupies stream bits 12p-4 .. 12p+7, MSB first
  task automatic build(int n_in);
    int n;
    bit stopped;
    n = (n_in > 4) ? 4 : n_in;
    stopped = 0;
    exp_q.delete();
    for (int k = 0; k < n; k++) begin
      int p, t, lo, hi;
      bit bad;
      int m [2];
      p = tp_pos[k]; t = tp_pat[k];
      bad = (p > LASTP);
      m[0] = 0; m[1] = 0;
      lo = (p == 0) ? 0 : (12*p - 4) / 8;
      hi = (12*p + 7) / 8;
      if (!bad) begin
        for (int b = 0; b < 12; b++) begin
          int s, bv;
          s = 12*p - 4 + b;
          bv = (t >> (11 - b)) & 1;
          if (s < 0) begin
            if (bv != 0) bad = 1;
          end else begin
            m[s/8 - lo] = m[s/8 - lo] ^ (bv << (7 - s%8));
          end
        end
      end
      if (bad) begin
        exp_q.push_back(mk(0, 0, 1, 1, 0, 0, 0));
        stopped = 1;
        break;
      end
      for (int a = lo; a <= hi; a++) begin
        exp_q.push_back(mk(1, 0, 0, 0, 0, a, 0));
        exp_q.push_back(mk(0, 1, 0, 0, 0, a, int'(shadow[a]) ^ m[a-lo]));
        shadow[a] = shadow[a] ^ 8'(m[a-lo]);
      end
    end
    if (!stopped) exp_q.push_back(mk(0, 0, 1, 0, n, 0, 0));
    exp_q.push_back(mk(0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic cmp(string tag, int cyc, rec_t e);
    bit bad;
    bad = (rd != e.rd) || (wr != e.wr) || (done != e.done)
       || ((rd || wr) && addr != e.addr) || (wr && wdata != e.wd)
       || (done && (fail != e.fail || fixed != e.cnt));
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s cyc %0d: got rd=%b wr=%b a=%0d wd=%h done=%b fail=%b n=%0d exp rd=%b wr=%b a=%0d wd=%h done=%b fail=%b n=%0d",
               tag, cyc, rd, wr, addr, wdata, done, fail, fixed,
               e.rd, e.wr, e.addr, e.wd, e.done, e.fail, e.cnt);
    end
  endtask

  task automatic run(string tag, int n_in, bit poke);
    int nd, first;
    build(n_in);
    @(negedge clk);
    start = 1'b1;
    cnt = 3'(n_in);
    for (int k = 0; k < 4; k++) begin
      pos_v[k*11 +: 11] = 11'(tp_pos[k]);
      pat_v[k*12 +: 12] = 12'(tp_pat[k]);
    end
    for (int i = 0; i < exp_q.size(); i++) begin
      @(negedge clk);
      start = 1'b0;
      cmp(tag, i, exp_q[i]);
      if (poke && i == 0) begin
        start = 1'b1;
        cnt = 3'd4;
        pos_v = {4{11'd3}};
        pat_v = {4{12'hFFF}};
      end
    end
    nd = 0; first = -1;
    for (int a = 0; a < MEMB; a++)
      if (ram[a] != shadow[a]) begin
        nd++;
        if (first < 0) first = a;
      end
    n_chk++;
    if (nd != 0) begin
      n_bad++;
      $display("FAIL %s buffer: %0d bytes differ, first addr %0d got %h exp %h",
               tag, nd, first, ram[first], shadow[first]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog expired: got hang exp done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < MEMB; a++) begin
      ram[a] = 8'(a * 37 + 11);
      shadow[a] = 8'(a * 37 + 11);
    end
    for (int k = 0; k < 4; k++) set_pair(k, 0, 0);
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd || wr || done || fail || fixed != 0) begin
      n_bad++;
      $display("FAIL R12 reset: got rd=%b wr=%b done=%b fail=%b n=%0d exp all 0", rd, wr, done, fail, fixed);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rd || wr || done || fail || fixed != 0) begin
      n_bad++;
      $display("FAIL R12 after reset: got rd=%b wr=%b done=%b fail=%b n=%0d exp all 0", rd, wr, done, fail, fixed);
    end

    set_pair(0, 1, 'hABC);                run("R1 odd", 1, 0);
    set_pair(0, 777, 'h5C3);              run("R1 odd mid", 1, 0);
    set_pair(0, 2, 'h5A3);                run("R2 even", 1, 0);
    set_pair(0, 1000, 'hF0F);             run("R2 even mid", 1, 0);
    set_pair(0, 0, 'h07E);                run("R3 zero ok", 1, 0);
    set_pair(0, 0, 'h1FF);                run("R3 zero fail", 1, 0);
    set_pair(0, 1365, 'hFFF);             run("R4 boundary", 1, 0);
    set_pair(0, 1367, 'h9A5); set_pair(1, 1374, 'h3C6);
                                          run("R5 spare", 2, 0);
    set_pair(0, 1375, 'h001);             run("R6 limit", 1, 0);
    set_pair(0, 2047, 'h123);             run("R6 top", 1, 0);
    set_pair(0, 3, 'h111); set_pair(1, 4, 'h222);
    set_pair(2, 0, 'h0AA); set_pair(3, 1366, 'h777);
                                          run("R7 four pairs", 4, 0);
    set_pair(0, 10, 'h456); set_pair(1, 11, 'h789);
    set_pair(2, 1400, 'h001); set_pair(3, 12, 'hFFF);
                                          run("R8 mid fail", 4, 0);
    set_pair(0, 5, 'h0F0); set_pair(1, 0, 'h100);
    set_pair(2, 6, 'h001); set_pair(3, 7, 'h002);
                                          run("R8 zero fail", 4, 0);
    run("R9 empty", 0, 0);
    set_pair(0, 20, 'h3A5); set_pair(1, 21, 'hC5A);
    set_pair(2, 22, 'h0FF); set_pair(3, 23, 'hF00);
                                          run("R9 full", 4, 0);
    set_pair(0, 40, 'hBEE); set_pair(1, 41, 'h0DE);
                                          run("R10 busy start", 2, 1);
    set_pair(0, 50, 'h111); set_pair(1, 51, 'h222);
    set_pair(2, 52, 'h333); set_pair(3, 53, 'h444);
                                          run("R11 clamp", 7, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule